// File: doc/BRIEF.md
# Pulse-Width Capture Timer

This block measures how long a digital input stays high and how long it stays low, the usual first step in decoding infrared remote-control frames and other pulse-coded signals. The input is brought into the clock domain through two flip-flops, cleaned by a programmable glitch filter and passed to an edge detector. The edge detector can be set to respond to rising edges only, falling edges only, or both.

Enabling the block loads an 8-bit down counter with all ones and holds it there. Counting starts on the first qualifying edge. Each later qualifying edge stores the current count and reloads all ones in the same clock. A falling edge ends a high interval, so its count goes to the high-time register. A rising edge ends a low interval, so its count goes to the low-time register. If 256 clocks pass with no qualifying edge, the counter times out, sets a flag and returns to its armed state. Software sets the mode and the interrupt masks and clears the flags through a small register port.

Top module: `pwcap_timer`

## Requirements
- R1: While enabled and armed, the counter holds 0xFF. The first qualifying edge starts the countdown and captures nothing.
- R2: Each later qualifying edge, arriving E clocks after the previous one, captures the value 256−E and reloads 0xFF in that same clock, so no counts are lost.
- R3: A falling edge stores its count in the high-time register and a rising edge stores its count in the low-time register. The other register keeps its value.
- R4: The edge field ctrl[2:1] selects the qualifying edges: 00 is rising only, 01 is falling only, 10 or 11 is both. An edge that is not selected neither captures nor restarts the counter.
- R5: The filtered level takes a new input value only after the synchronised input has held that value for L+1 clocks, where L is ctrl[7:5]. A pulse of L clocks or fewer is ignored. A capture caused by an input change appears at the (L+4)th rising clock edge after the change.
- R6: If the running counter reaches 0 and no qualifying edge arrives in that clock, the timeout flag (status bit 1) is set and the counter returns to the armed state at 0xFF.
- R7: A capture sets the capture flag (status bit 0). cap_irq is the capture flag gated by ctrl[3], and tmo_irq is the timeout flag gated by ctrl[4].
- R8: Register addresses are as follows. Address 0 is ctrl, which can be read and written. Address 1 is status: bit 0 is the capture flag and bit 1 is the timeout flag. Writing 1 to a status bit clears that bit, and a new event in the same clock takes priority over the clear. Address 2 is the high capture and address 3 is the low capture, both read-only. All registers reset to 0.
- R9: Clearing ctrl[0] returns the counter to the armed state. The capture registers and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous pulse input to be measured |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| hi_cap | output | 8 | Last count captured for a high interval |
| lo_cap | output | 8 | Last count captured for a low interval |
| cap_irq | output | 1 | Masked capture interrupt |
| tmo_flag | output | 1 | Timeout status flag |
| tmo_irq | output | 1 | Masked timeout interrupt |

## Verification
A change on sig_in produces its capture, capture flag and capture interrupt at the (L+4)th rising edge after the change. Two cycles go to synchronisation and L+1 to the filter, and the qualified edge is registered one edge later. The bench changes sig_in on falling edges. For the falling edge in each sweep it reads the status one falling edge before the result is due and again on the falling edge that follows it, so both the latency and the value are pinned. Captured values are checked against 256 minus the programmed interval for filter lengths 0, 3 and 7. The timeout is checked both before and after the 256-clock window closes.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_FALL     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_mode_e;

    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_HCAP = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_LCAP = 2'd3;

    // ctrl field positions
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MODE_LO  = 1;
    localparam int unsigned CTRL_CAPM_BIT = 3;
    localparam int unsigned CTRL_TMOM_BIT = 4;
    localparam int unsigned CTRL_FLT_LO   = 5;

endpackage

// File: rtl/pwcap_filter.sv
module pwcap_filter #(
    parameter int unsigned LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [LEN_W-1:0] min_len,
    output logic             level,
    output logic             sync_lvl
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [LEN_W-1:0] run;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.lvl) begin
            st_d.run = '0;
        end else if (st_q.run == min_len) begin
            // held for min_len+1 clocks: accept the new level
            st_d.lvl = st_q.s2;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = st_q.lvl;
    assign sync_lvl = st_q.s2;

endmodule

// File: rtl/pwcap_edge.sv
module pwcap_edge
    import pwcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  edge_mode_e mode,
    output logic       rise,
    output logic       fall,
    output logic       qual
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
        rise      = level & ~st_q.prev;
        fall      = ~level & st_q.prev;
        unique case (mode)
            EDGE_RISE: qual = rise;
            EDGE_FALL: qual = fall;
            default:   qual = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_hit,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             capture,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        timeout = 1'b0;
        if (!en) begin
            st_d.run = 1'b0;
            st_d.cnt = FULL;
        end else if (!st_q.run) begin
            // armed: hold full until the first qualifying edge
            st_d.cnt = FULL;
            if (edge_hit) st_d.run = 1'b1;
        end else if (edge_hit) begin
            capture  = 1'b1;
            st_d.cnt = FULL;
        end else if (st_q.cnt == '0) begin
            timeout  = 1'b1;
            st_d.run = 1'b0;
            st_d.cnt = FULL;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run <= 1'b0;
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;

endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
    import pwcap_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FILT_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sig_in,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [CNT_W-1:0]      hi_cap,
    output logic [CNT_W-1:0]      lo_cap,
    output logic                  cap_irq,
    output logic                  tmo_flag,
    output logic                  tmo_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              cap_f;
        logic              tmo_f;
        logic [CNT_W-1:0]  hcap;
        logic [CNT_W-1:0]  lcap;
    } regs_t;

    regs_t r_d, r_q;

    logic              en_w;
    logic              cap_mask_w;
    logic              tmo_mask_w;
    edge_mode_e        mode_w;
    logic [FILT_W-1:0] min_len_w;
    logic              filt_lvl;
    logic              sync_lvl;
    logic              rise;
    logic              fall;
    logic              qual;
    logic [CNT_W-1:0]  count;
    logic              running;
    logic              capture;
    logic              timeout;

    assign en_w       = r_q.ctrl[CTRL_EN_BIT];
    assign cap_mask_w = r_q.ctrl[CTRL_CAPM_BIT];
    assign tmo_mask_w = r_q.ctrl[CTRL_TMOM_BIT];
    assign mode_w     = edge_mode_e'(r_q.ctrl[CTRL_MODE_LO +: 2]);
    assign min_len_w  = r_q.ctrl[CTRL_FLT_LO +: FILT_W];

    pwcap_filter #(.LEN_W(FILT_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (sig_in),
        .min_len  (min_len_w),
        .level    (filt_lvl),
        .sync_lvl (sync_lvl)
    );

    pwcap_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (filt_lvl),
        .mode  (mode_w),
        .rise  (rise),
        .fall  (fall),
        .qual  (qual)
    );

    pwcap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .edge_hit (qual),
        .count    (count),
        .running  (running),
        .capture  (capture),
        .timeout  (timeout)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_addr == ADDR_CTRL) begin
            r_d.ctrl = wr_data;
        end
        if (wr_en && wr_addr == ADDR_STAT) begin
            if (wr_data[0]) r_d.cap_f = 1'b0;
            if (wr_data[1]) r_d.tmo_f = 1'b0;
        end
        // events take priority over a clear in the same clock
        if (capture) begin
            r_d.cap_f = 1'b1;
            if (fall) r_d.hcap = count;
            else      r_d.lcap = count;
        end
        if (timeout) begin
            r_d.tmo_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = r_q.ctrl;
            ADDR_STAT: rd_data = DATA_W'({r_q.tmo_f, r_q.cap_f});
            ADDR_HCAP: rd_data = DATA_W'(r_q.hcap);
            default:   rd_data = DATA_W'(r_q.lcap);
        endcase
    end

    assign hi_cap   = r_q.hcap;
    assign lo_cap   = r_q.lcap;
    assign tmo_flag = r_q.tmo_f;
    assign cap_irq  = r_q.cap_f & cap_mask_w;
    assign tmo_irq  = r_q.tmo_f & tmo_mask_w;

endmodule

// File: rtl/pwcap_timer_chk.sv
module pwcap_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             qual,
    input logic             rise,
    input logic             fall,
    input logic             capture,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             filt_lvl,
    input logic             sync_lvl,
    input logic [CNT_W-1:0] hi_cap,
    input logic [CNT_W-1:0] lo_cap,
    input logic             tmo_flag,
    input logic             cap_irq,
    input logic             cap_mask
);

    localparam logic [CNT_W-1:0] FULL = '1;

    p_idle_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> count == FULL);

    p_first_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !running && qual) |=> (running && count == FULL && $stable(hi_cap) && $stable(lo_cap)));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && qual) |=> (running && count == FULL));

    p_hi_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && fall) |=> (hi_cap == $past(count) && $stable(lo_cap)));

    p_lo_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rise) |=> (lo_cap == $past(count) && $stable(hi_cap)));

    p_filter_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_lvl) |-> filt_lvl == $past(sync_lvl));

    p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && count == '0 && !qual) |=> (tmo_flag && !running));

    p_cap_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cap_mask) |=> (cap_irq || !cap_mask));

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !running);

endmodule

bind pwcap_timer pwcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_w),
    .qual     (qual),
    .rise     (rise),
    .fall     (fall),
    .capture  (capture),
    .running  (running),
    .count    (count),
    .filt_lvl (filt_lvl),
    .sync_lvl (sync_lvl),
    .hi_cap   (hi_cap),
    .lo_cap   (lo_cap),
    .tmo_flag (tmo_flag),
    .cap_irq  (cap_irq),
    .cap_mask (cap_mask_w)
);

// File: tb/pwcap_timer_bench.sv
module pwcap_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] hi_cap;
    logic [7:0] lo_cap;
    logic       cap_irq;
    logic       tmo_flag;
    logic       tmo_irq;

    int total = 0;
    int bad   = 0;
    int settle = 5;

    always #2 clk = ~clk;

    pwcap_timer u_pwcap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hi_cap   (hi_cap),
        .lo_cap   (lo_cap),
        .cap_irq  (cap_irq),
        .tmo_flag (tmo_flag),
        .tmo_irq  (tmo_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic go(input logic lvl);
        sig_in = lvl;
        repeat (settle) @(negedge clk);
    endtask

    task automatic pad(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mkctrl(input logic en, input logic [1:0] mode,
                                          input logic capm, input logic tmom, input int flen);
        return {3'(flen), tmom, capm, mode, en};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int prev_hi;
        int prev_lo;
        int hw;
        int lw;
        int lf;

        pad(5);
        rst_n = 1'b1;
        pad(2);

        // R8: reset state
        rd(2'd0, d); chk("R8 ctrl reset", d, 0);
        rd(2'd1, d); chk("R8 status reset", d, 0);
        rd(2'd2, d); chk("R8 hcap reset", d, 0);
        rd(2'd3, d); chk("R8 lcap reset", d, 0);
        chk("R7 irq reset", {cap_irq, tmo_irq}, 0);

        // R8: ctrl read back
        wr(2'd0, 8'hB4);
        rd(2'd0, d); chk("R8 ctrl readback", d, 8'hB4);
        wr(2'd0, 8'h00);

        // Sweep: both edges, several filter lengths and widths (R1 R2 R3 R5 R7)
        for (int li = 0; li < 3; li++) begin
            lf = (li == 0) ? 0 : (li == 1) ? 3 : 7;
            settle = lf + 5;
            for (int pi = 0; pi < 4; pi++) begin
                hw = (pi == 0) ? 20 : (pi == 1) ? 37 : (pi == 2) ? 100 : 200;
                lw = (pi == 0) ? 40 : (pi == 1) ? 25 : (pi == 2) ? 60 : 150;
                wr(2'd0, 8'h00);
                wr(2'd0, mkctrl(1'b1, 2'b10, 1'b1, 1'b1, lf));
                wr(2'd1, 8'h03);
                go(1'b1);
                rd(2'd1, d); chk("R1 first edge captures nothing", d[0], 0);
                pad(hw - settle);
                sig_in = 1'b0;
                pad(lf + 3);
                rd(2'd1, d); chk("R5 capture not before L+4 edges", d[0], 0);
                pad(1);
                rd(2'd1, d); chk("R5 capture due at L+4 edges", d[0], 1);
                pad(1);
                chk("R3 falling edge to high register", hi_cap, 256 - hw);
                chk("R7 cap_irq with mask set", cap_irq, 1);
                pad(lw - settle);
                go(1'b1);
                chk("R3 rising edge to low register", lo_cap, 256 - lw);
                chk("R2 high register kept", hi_cap, 256 - hw);
                pad(20 - settle);
                go(1'b0);
                chk("R2 back-to-back capture", hi_cap, 236);
            end
        end

        // R4: rising edges only, period goes to low register
        lf = 2; settle = lf + 5;
        wr(2'd0, 8'h00);
        wr(2'd0, mkctrl(1'b1, 2'b00, 1'b1, 1'b0, lf));
        wr(2'd1, 8'h03);
        prev_hi = hi_cap;
        go(1'b1); pad(30 - settle);
        go(1'b0);
        rd(2'd1, d); chk("R4 falling edge ignored in rise mode", d[0], 0);
        pad(50 - settle);
        go(1'b1);
        chk("R4 rise mode period", lo_cap, 256 - 80);
        chk("R4 rise mode leaves high register", hi_cap, prev_hi);
        pad(20 - settle);
        go(1'b0);

        // R4: falling edges only
        wr(2'd0, 8'h00);
        wr(2'd0, mkctrl(1'b1, 2'b01, 1'b1, 1'b0, lf));
        wr(2'd1, 8'h03);
        prev_lo = lo_cap;
        go(1'b1);
        rd(2'd1, d); chk("R4 rising edge ignored in fall mode", d[0], 0);
        pad(25 - settle);
        go(1'b0);
        rd(2'd1, d); chk("R4 first falling edge arms", d[0], 0);
        pad(40 - settle);
        go(1'b1);
        pad(35 - settle);
        go(1'b0);
        chk("R4 fall mode period", hi_cap, 256 - 75);
        chk("R4 fall mode leaves low register", lo_cap, prev_lo);

        // R5: glitch filter with L = 4
        lf = 4; settle = lf + 5;
        wr(2'd0, 8'h00);
        wr(2'd0, mkctrl(1'b1, 2'b10, 1'b1, 1'b0, lf));
        go(1'b1); pad(30 - settle);
        go(1'b0);                                 // t0, elapsed settle
        chk("R5 filtered capture", hi_cap, 226);
        wr(2'd1, 8'h03);                          // elapsed settle + 2
        prev_lo = lo_cap;
        pad(40 - settle - 2);
        sig_in = 1'b1; pad(4); sig_in = 1'b0;     // 4-clock glitch at t0+40
        pad(settle);
        rd(2'd1, d); chk("R5 short pulse ignored", d[0], 0);
        chk("R5 short pulse leaves low register", lo_cap, prev_lo);
        pad(80 - 44 - settle);
        sig_in = 1'b1; pad(5); sig_in = 1'b0;     // 5-clock pulse at t0+80
        pad(settle);
        chk("R5 pulse of L+1 passes", lo_cap, 256 - 80);
        chk("R5 pulse width captured", hi_cap, 256 - 5);

        // R6 / R7: timeout and masks
        lf = 0; settle = 5;
        wr(2'd0, 8'h00);
        wr(2'd0, mkctrl(1'b1, 2'b10, 1'b0, 1'b1, lf));
        wr(2'd1, 8'h03);
        prev_hi = hi_cap;
        go(1'b1);
        pad(200);
        chk("R6 no timeout before window", tmo_flag, 0);
        pad(100);
        chk("R6 timeout flag", tmo_flag, 1);
        chk("R7 tmo_irq with mask set", tmo_irq, 1);
        rd(2'd1, d); chk("R8 status shows timeout only", d, 2);
        go(1'b0);
        rd(2'd1, d); chk("R6 re-armed after timeout", d[0], 0);
        chk("R6 no capture after timeout", hi_cap, prev_hi);
        pad(30 - settle);
        go(1'b1);
        chk("R6 capture after re-arm", lo_cap, 226);
        chk("R7 cap_irq masked", cap_irq, 0);
        wr(2'd0, mkctrl(1'b1, 2'b10, 1'b1, 1'b1, lf));
        chk("R7 cap_irq after unmask", cap_irq, 1);
        wr(2'd1, 8'h01);
        chk("R8 clear capture flag", cap_irq, 0);
        chk("R8 timeout flag kept", tmo_flag, 1);
        wr(2'd1, 8'h02);
        chk("R8 clear timeout flag", tmo_flag, 0);
        rd(2'd2, d); chk("R8 hcap readable", d, hi_cap);
        rd(2'd3, d); chk("R8 lcap readable", d, 226);

        // R9: disable and re-enable
        pad(20);
        go(1'b0);
        pad(30 - settle);
        go(1'b1);
        pad(30 - settle);
        go(1'b0);
        chk("R9 capture before disable", hi_cap, 226);
        wr(2'd0, mkctrl(1'b0, 2'b10, 1'b1, 1'b1, lf));
        chk("R9 high register kept", hi_cap, 226);
        chk("R9 capture flag kept", cap_irq, 1);
        wr(2'd0, mkctrl(1'b1, 2'b10, 1'b1, 1'b1, lf));
        wr(2'd1, 8'h03);
        go(1'b1);
        rd(2'd1, d); chk("R9 first edge after re-enable arms", d[0], 0);
        pad(40 - settle);
        go(1'b0);
        chk("R9 capture after re-enable", hi_cap, 216);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule